// File: doc/BRIEF.md
# Multi-Operand Carry-Save Adder/Subtractor

This combinational block adds or subtracts a parameterized number of operands and returns one result of width `SUM_W`, wrapped modulo 2^`SUM_W`. Every operand has its own bit width, fixed at elaboration, and sits in its own slice of one packed input bus. Per-operand flags choose two's-complement or unsigned widening, and addition or subtraction.

Each operand is first widened or truncated to `SUM_W` bits. An operand marked for subtraction is then bitwise inverted. A single extra summand holds the number of subtracted operands, and this restores the missing +1 for all of them together. The summand list passes through layers of 3:2 full-adder compressors. Triples are taken in list order, and any leftover summands are appended after the new sum/carry pairs. The reduction stops when two vectors remain, and one carry-propagate adder then produces the result.

The correction slot always exists. It holds zero when no operand is subtracted, so the number of layers depends only on the operand count. The block is meant to replace a chain of ordinary adders where several values meet in one sum.

Top module: `csaMultiAdder`

## Requirements
- R1: `sumOut` equals the sum modulo 2^SUM_W of all resized operands, each taken positive or negative according to its flag, and any carry beyond bit SUM_W-1 is lost. Operand i occupies `opBus` starting at the sum of the widths of operands 0..i-1 (operand 0 in the least significant bits), and bit i of `signFlags` and of `subFlags` belongs to operand i.
- R2: An operand narrower than SUM_W whose sign flag is 0 is padded with zeros above its top bit.
- R3: An operand narrower than SUM_W whose sign flag is 1 is padded with copies of its own top bit.
- R4: An operand wider than SUM_W contributes only its low SUM_W bits, and its sign flag has no effect on the result.
- R5: An operand whose subtract flag is 1 contributes the two's-complement negation of its resized value. This holds for any number of subtracted operands, from one up to all of them.
- R6: The correction summand equals the count of set subtract flags modulo 2^SUM_W, and it is zero when no subtract flag is set. For example, subtracting three zero operands gives a result of zero.
- R7: Every compressor layer preserves the modulo-2^SUM_W total of the summands, so the two vectors that reach the final adder carry the same total as the resized list.
- R8: The block has no clock or storage. `sumOut` follows a change of any input within the same time step, for any mix of flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opBus | input | BUS_W (sum of per-operand widths) | Packed operands, operand 0 in the least significant bits |
| signFlags | input | NUM_OPS | 1 = widen operand i with its top bit, 0 = widen with zeros |
| subFlags | input | NUM_OPS | 1 = subtract operand i, 0 = add it |
| sumOut | output | SUM_W | Wrapped total |

## Verification
Directed cases isolate the widening rules:
- A lone all-ones operand that is narrower than the result shows zero padding against sign padding.
- A lone wide operand, tried with both sign settings, shows that the high bits and the sign flag are dropped.

Subtraction cases check the correction term:
- Subtracting zero operands, singly and several at once, isolates the correction count.
- Subtracting every operand shows that the count and the inversion combine correctly.

An all-ones, all-add case forces carries to ripple out of the top bit and be discarded. Seeded random operand and flag mixes then drive values through every compressor layer and leftover path. The results are compared with a bench model that works on each operand's bits directly.

// File: rtl/csaPkg.sv
package csaPkg;

  // Upper bound on operands for the packed width-descriptor argument.
  localparam int MAX_OPS = 64;

  // Summands left after one 3:2 compression layer.
  function automatic int nextCount(int cnt);
    return 2 * (cnt / 3) + (cnt % 3);
  endfunction

  // Summand count after a given number of layers.
  function automatic int countAt(int cnt, int layers);
    int c = cnt;
    for (int k = 0; k < layers; k++) c = nextCount(c);
    return c;
  endfunction

  // Layers needed to bring the list down to two summands.
  function automatic int layerCount(int cnt);
    int c = cnt;
    int n = 0;
    while (c > 2) begin
      c = nextCount(c);
      n++;
    end
    return n;
  endfunction

  // Bit offset of operand idx in the packed bus (8-bit width fields).
  function automatic int fieldOffset(logic [8*MAX_OPS-1:0] widths, int idx);
    int acc = 0;
    for (int j = 0; j < idx; j++) acc += int'(widths[j*8 +: 8]);
    return acc;
  endfunction

endpackage

// File: rtl/csaOperandPrep.sv
module csaOperandPrep #(
  parameter int IN_W  = 8,
  parameter int SUM_W = 12
) (
  input  logic [IN_W-1:0]  opBits,
  input  logic             isSigned,
  input  logic             isSub,
  output logic [SUM_W-1:0] termOut
);

  logic [SUM_W-1:0] resized;

  generate
    if (IN_W > SUM_W) begin : gTrunc
      logic unusedHigh;
      assign unusedHigh = ^{opBits[IN_W-1:SUM_W], isSigned};
      assign resized = opBits[SUM_W-1:0];
    end else if (IN_W == SUM_W) begin : gSame
      logic unusedSign;
      assign unusedSign = isSigned;
      assign resized = opBits;
    end else begin : gWiden
      logic padBit;
      assign padBit = isSigned & opBits[IN_W-1];
      assign resized = {{(SUM_W-IN_W){padBit}}, opBits};
    end
  endgenerate

  assign termOut = isSub ? ~resized : resized;

endmodule

// File: rtl/csaCompressLayer.sv
module csaCompressLayer #(
  parameter int SUM_W  = 12,
  parameter int IN_CNT = 6,
  localparam int GROUPS  = IN_CNT / 3,
  localparam int LEFT    = IN_CNT % 3,
  localparam int OUT_CNT = 2 * GROUPS + LEFT
) (
  input  logic [IN_CNT-1:0][SUM_W-1:0]  inVec,
  output logic [OUT_CNT-1:0][SUM_W-1:0] outVec
);

  generate
    for (genvar g = 0; g < GROUPS; g++) begin : gTriple
      logic [SUM_W-1:0] aIn, bIn, cIn;
      assign aIn = inVec[3*g];
      assign bIn = inVec[3*g+1];
      assign cIn = inVec[3*g+2];

      assign outVec[2*g] = aIn ^ bIn ^ cIn;
      assign outVec[2*g+1][0] = 1'b0;
      for (genvar b = 0; b < SUM_W - 1; b++) begin : gCarry
        assign outVec[2*g+1][b+1] = (aIn[b] & bIn[b]) | (aIn[b] & cIn[b]) | (bIn[b] & cIn[b]);
      end
    end

    for (genvar r = 0; r < LEFT; r++) begin : gPass
      assign outVec[2*GROUPS+r] = inVec[3*GROUPS+r];
    end
  endgenerate

endmodule

// File: rtl/csaMultiAdder.sv
module csaMultiAdder #(
  parameter int NUM_OPS = 5,
  parameter int SUM_W   = 12,
  parameter logic [NUM_OPS*8-1:0] OP_WIDTHS = {8'd12, 8'd4, 8'd16, 8'd12, 8'd8},
  localparam int BUS_W = csaPkg::fieldOffset((8*csaPkg::MAX_OPS)'(OP_WIDTHS), NUM_OPS)
) (
  input  logic [BUS_W-1:0]   opBus,
  input  logic [NUM_OPS-1:0] signFlags,
  input  logic [NUM_OPS-1:0] subFlags,
  output logic [SUM_W-1:0]   sumOut
);

  localparam int TERM_CNT   = NUM_OPS + 1;
  localparam int NUM_LAYERS = csaPkg::layerCount(TERM_CNT);

  logic [TERM_CNT-1:0][SUM_W-1:0] termVec;
  logic [SUM_W-1:0] corrTerm;
  logic [SUM_W-1:0] finalA, finalB;

  // Resize and conditionally invert each operand.
  generate
    for (genvar i = 0; i < NUM_OPS; i++) begin : gPrep
      localparam int OW  = int'(OP_WIDTHS[i*8 +: 8]);
      localparam int OFF = csaPkg::fieldOffset((8*csaPkg::MAX_OPS)'(OP_WIDTHS), i);
      csaOperandPrep #(.IN_W(OW), .SUM_W(SUM_W)) uPrep (
        .opBits  (opBus[OFF +: OW]),
        .isSigned(signFlags[i]),
        .isSub   (subFlags[i]),
        .termOut (termVec[i])
      );
    end
  endgenerate

  // One combined +1 per inverted operand.
  always_comb begin
    corrTerm = '0;
    for (int i = 0; i < NUM_OPS; i++) corrTerm = corrTerm + SUM_W'(subFlags[i]);
  end
  assign termVec[NUM_OPS] = corrTerm;

  // Compression layers, chained through generate scopes.
  generate
    for (genvar k = 0; k < NUM_LAYERS; k++) begin : layerStage
      localparam int IN_C  = csaPkg::countAt(TERM_CNT, k);
      localparam int OUT_C = csaPkg::countAt(TERM_CNT, k + 1);
      logic [OUT_C-1:0][SUM_W-1:0] nextVec;
      if (k == 0) begin : gFirst
        csaCompressLayer #(.SUM_W(SUM_W), .IN_CNT(IN_C)) uLayer (
          .inVec (termVec),
          .outVec(nextVec)
        );
      end else begin : gLater
        csaCompressLayer #(.SUM_W(SUM_W), .IN_CNT(IN_C)) uLayer (
          .inVec (layerStage[k-1].nextVec),
          .outVec(nextVec)
        );
      end
    end

    if (NUM_LAYERS == 0) begin : gDirectPair
      assign finalA = termVec[0];
      assign finalB = termVec[1];
    end else begin : gReducedPair
      assign finalA = layerStage[NUM_LAYERS-1].nextVec[0];
      assign finalB = layerStage[NUM_LAYERS-1].nextVec[1];
    end
  endgenerate

  // Final carry-propagate adder; carry-out discarded.
  assign sumOut = finalA + finalB;

endmodule

// File: rtl/csaSumChecker.sv
module csaSumChecker #(
  parameter int NUM_OPS = 5,
  parameter int SUM_W   = 12,
  localparam int TERM_CNT = NUM_OPS + 1
) (
  input logic [TERM_CNT-1:0][SUM_W-1:0] termVec,
  input logic [NUM_OPS-1:0]             subFlags,
  input logic [SUM_W-1:0]               finalA,
  input logic [SUM_W-1:0]               finalB,
  input logic [SUM_W-1:0]               sumOut
);

  logic [SUM_W-1:0] listTotal;
  logic [SUM_W-1:0] pairTotal;

  always_comb begin
    listTotal = '0;
    for (int i = 0; i < TERM_CNT; i++) listTotal = listTotal + termVec[i];
    pairTotal = finalA + finalB;
  end

  always_comb begin
    // R6: correction slot tracks the number of subtracted operands
    p_corr_count_r6: assert (termVec[NUM_OPS] == SUM_W'($countones(subFlags)))
      else $error("correction summand mismatch");
    // R6: no subtraction leaves the correction slot at zero
    p_idle_corr_r6: assert (subFlags != '0 || termVec[NUM_OPS] == '0)
      else $error("correction summand nonzero without subtraction");
    // R7: compression keeps the total
    p_pair_conserved_r7: assert (pairTotal == listTotal)
      else $error("compression changed the total");
    // R1: output equals the total of the resized list
    p_result_total_r1: assert (sumOut == listTotal)
      else $error("result differs from summand total");
  end

endmodule

bind csaMultiAdder csaSumChecker #(.NUM_OPS(NUM_OPS), .SUM_W(SUM_W)) uSumChk (
  .termVec (termVec),
  .subFlags(subFlags),
  .finalA  (finalA),
  .finalB  (finalB),
  .sumOut  (sumOut)
);

// File: tb/csaMultiAdder_test.sv
`timescale 1ns/1ps
module csaMultiAdder_test;

  localparam int NUM_OPS = 5;
  localparam int SUM_W   = 12;
  localparam logic [NUM_OPS*8-1:0] WIDTHS = {8'd12, 8'd4, 8'd16, 8'd12, 8'd8};
  localparam int BUS_W = 8 + 12 + 16 + 4 + 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [BUS_W-1:0]   opBus;
  logic [NUM_OPS-1:0] signFlags;
  logic [NUM_OPS-1:0] subFlags;
  logic [SUM_W-1:0]   sumOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  csaMultiAdder #(.NUM_OPS(NUM_OPS), .SUM_W(SUM_W), .OP_WIDTHS(WIDTHS)) uut (
    .opBus(opBus), .signFlags(signFlags), .subFlags(subFlags), .sumOut(sumOut)
  );

  function automatic int opWidth(int i);
    return int'(WIDTHS[i*8 +: 8]);
  endfunction

  function automatic int opOffset(int i);
    int acc = 0;
    for (int j = 0; j < i; j++) acc += opWidth(j);
    return acc;
  endfunction

  function automatic logic [SUM_W-1:0] modelSum(logic [BUS_W-1:0] bus,
                                                logic [NUM_OPS-1:0] sg,
                                                logic [NUM_OPS-1:0] sb);
    logic [SUM_W-1:0] acc = '0;
    for (int i = 0; i < NUM_OPS; i++) begin
      logic [SUM_W-1:0] v;
      int w = opWidth(i);
      int o = opOffset(i);
      for (int b = 0; b < SUM_W; b++) begin
        if (b < w) v[b] = bus[o+b];
        else v[b] = sg[i] ? bus[o+w-1] : 1'b0;
      end
      acc = sb[i] ? acc - v : acc + v;
    end
    return acc;
  endfunction

  function automatic logic [BUS_W-1:0] placeOp(int i, logic [31:0] val);
    logic [BUS_W-1:0] r = '0;
    for (int b = 0; b < opWidth(i); b++) r[opOffset(i)+b] = val[b];
    return r;
  endfunction

  task automatic compare(string req, logic [SUM_W-1:0] expVal);
    checks++;
    if (sumOut !== expVal) begin
      failures++;
      $display("FAIL %s: sumOut=%h expected=%h (bus=%h sign=%b sub=%b)",
               req, sumOut, expVal, opBus, signFlags, subFlags);
    end
  endtask

  task automatic applyCase(string req, logic [BUS_W-1:0] bus,
                           logic [NUM_OPS-1:0] sg, logic [NUM_OPS-1:0] sb,
                           logic [SUM_W-1:0] expVal);
    @(posedge clk);
    opBus = bus; signFlags = sg; subFlags = sb;
    @(negedge clk);
    compare(req, expVal);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [BUS_W-1:0] bus;
    void'($urandom(32'h5EED_0123));
    opBus = '0; signFlags = '0; subFlags = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 reset state", '0);
    rst = 1'b0;

    // R2: 4-bit operand 3 all ones, unsigned -> 15
    applyCase("R2 zero pad", placeOp(3, 32'hF), 5'b00000, 5'b00000, 12'h00F);
    // R3: same operand signed -> -1
    applyCase("R3 sign pad", placeOp(3, 32'hF), 5'b01000, 5'b00000, 12'hFFF);
    // R3: 8-bit operand 0, value 0x80 signed -> 0xF80
    applyCase("R3 sign pad op0", placeOp(0, 32'h80), 5'b00001, 5'b00000, 12'hF80);
    // R4: 16-bit operand 2 keeps low 12 bits, sign flag ignored
    applyCase("R4 truncate unsigned", placeOp(2, 32'hABCD), 5'b00000, 5'b00000, 12'hBCD);
    applyCase("R4 truncate signed", placeOp(2, 32'hABCD), 5'b00100, 5'b00000, 12'hBCD);
    // R5: subtract 1 -> all ones
    applyCase("R5 single subtract", placeOp(0, 32'h1), 5'b00000, 5'b00001, 12'hFFF);
    // R6: three zero operands subtracted -> 0
    applyCase("R6 correction only", '0, 5'b00000, 5'b10101, 12'h000);
    applyCase("R6 all zero subtracted", '0, 5'b11111, 5'b11111, 12'h000);
    // R1: all ones unsigned, all added: 255+4095+4095+15+4095 wraps
    bus = '1;
    applyCase("R1 wrap", bus, 5'b00000, 5'b00000, modelSum(bus, 5'b00000, 5'b00000));
    // R5: everything subtracted
    applyCase("R5 all subtract", bus, 5'b00000, 5'b11111, modelSum(bus, 5'b00000, 5'b11111));
    applyCase("R5 all subtract signed", bus, 5'b11111, 5'b11111, modelSum(bus, 5'b11111, 5'b11111));
    // R1: 7 + 9 - 3 in three operands
    bus = placeOp(0, 7) | placeOp(1, 9) | placeOp(4, 3);
    applyCase("R1 mixed", bus, 5'b00000, 5'b10000, 12'h00D);

    // R7 / R1: random mixes through every layer
    for (int n = 0; n < 400; n++) begin
      logic [NUM_OPS-1:0] sg, sb;
      bus = {$urandom, $urandom};
      sg = NUM_OPS'($urandom);
      sb = NUM_OPS'($urandom);
      applyCase("R7 random", bus, sg, sb, modelSum(bus, sg, sb));
    end

    // R8: output follows input without a clock edge
    @(negedge clk);
    opBus = placeOp(1, 12'h123);
    signFlags = '0;
    subFlags = '0;
    #2;
    compare("R8 no clock", 12'h123);
    subFlags = 5'b00010;
    #2;
    compare("R8 no clock sub", 12'hEDD);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule